// File: doc/BRIEF.md
# Start/Stop Framed Serial Character Receiver

This block turns a start/stop framed serial line into parallel characters. The line is examined on pulses of a receive sample enable, and each bit lasts 1, 16 or 64 of those pulses, as configured. Before a character is accepted, the receiver checks that its start bit is real. It then collects 5 to 8 data bits, least significant first, and an optional parity bit, and it checks the first stop bit. The finished character is placed in a holding register together with its error flags, and a ready flag is raised.

A consumer reads the holding register whenever it likes and acknowledges the read with a one-cycle pulse. The receiver is still collecting the next character during that time, so the storage is double buffered. A character that arrives while the previous one is still unread replaces it and raises an overrun flag. When the line is held at space for a whole frame, the block raises a line-break output. That output stays high, and no new character is started, until the line goes back to mark.

Top module: `serial_char_receiver`

## Requirements
- R1: After reset, rx_ready, err_parity, err_frame, err_overrun and brk_det are all 0 and rx_data is 8'h00.
- R2: cfg_len selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. rx_data holds the character right-aligned, and the bits above the character length read as 0.
- R3: When cfg_par_en is 1, one parity bit follows the data. cfg_par_odd=1 selects odd parity and 0 selects even parity. err_parity is 1 when the data bits and the parity bit together have the wrong count of ones. err_parity is always 0 when cfg_par_en is 0.
- R4: Only the first stop bit is checked. If it is sampled low, err_frame is 1 for that character.
- R5: A character that finishes while rx_ready is still 1 and no rd_ack arrives in the same cycle replaces rx_data and sets err_overrun. A character that finishes with no unread character pending clears err_overrun.
- R6: With cfg_factor 16X or 64X, a low level is checked again half a bit time after it is first seen. If the line is high by then, the event is discarded and no character results.
- R7: cfg_factor 2'b00 selects 1X (one sample pulse per bit, and a low sample is taken as the start bit). 2'b01 selects 16X. 2'b10 and 2'b11 select 64X. In 16X and 64X, every later bit is sampled at its centre.
- R8: When the data bits, the parity bit (if enabled) and the stop bit are all 0, brk_det goes to 1 and the all-zero character is delivered with err_frame set. While brk_det is 1, no new character is started. brk_det returns to 0 at the first sample pulse that sees the line high.
- R9: A rd_ack pulse clears rx_ready. rx_data and the three error flags change only when a new character is delivered, and they are updated together with rx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | One-cycle receive sample pulse |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| cfg_factor | input | 2 | Sample pulses per bit: 00 1X, 01 16X, 1x 64X |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even parity |
| rd_ack | input | 1 | Holding register has been read |
| rx_data | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Unread character available |
| err_parity | output | 1 | Parity error of the held character |
| err_frame | output | 1 | Stop bit was low |
| err_overrun | output | 1 | Previous character was lost |
| brk_det | output | 1 | Line break in progress |

## Verification
The assertions assume that the configuration inputs change only while the receiver is idle between frames, and that samp_en is a single-cycle pulse. The stimulus meets both assumptions. It sets the configuration only after a mark gap of at least two bit times. It changes rxd only just after a sample pulse, and it holds each bit for exactly the selected number of pulses. Corner cases covered by directed tests are noise pulses shorter than half a bit, a frame of all zeros held past its stop bit, and two characters received without a read in between.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int CHAR_MAX = 8;
    localparam logic [1:0] FAC_1X  = 2'b00;
    localparam logic [1:0] FAC_16X = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_BITS, ST_PAR, ST_STOP
    } srx_state_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                perr;
        logic                ferr;
        logic                brk;
    } srx_char_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        for (int i = STAGES-1; i > 0; i--) chain_d[i] = chain_q[i-1];
        chain_d[0] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_factor,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    output logic       done,
    output srx_char_t  res,
    output logic       brk_det
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam int DIV_W = CNT_W + 1;
    localparam int IDX_W = $clog2(CHAR_MAX);

    typedef struct packed {
        srx_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [CHAR_MAX-1:0] shreg;
        logic                par;
        logic                brk;
    } frame_st_t;

    frame_st_t q, d;
    logic [DIV_W-1:0] div, half;
    logic [IDX_W-1:0] last_idx;
    logic             at_end;

    always_comb begin
        d    = q;
        done = 1'b0;
        res  = '0;
        unique case (cfg_factor)
            FAC_1X:  div = DIV_W'(1);
            FAC_16X: div = DIV_W'(FAST_DIV);
            default: div = DIV_W'(SLOW_DIV);
        endcase
        half     = div >> 1;
        last_idx = IDX_W'(cfg_len) + IDX_W'(4);
        at_end   = ({1'b0, q.cnt} == div - 1'b1);
        if (tick) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (q.brk) begin
                        if (line) d.brk = 1'b0;
                    end else if (!line) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.shreg = '0;
                        d.par   = 1'b0;
                        d.state = (div == DIV_W'(1)) ? ST_BITS : ST_START;
                    end
                end
                ST_START: begin
                    if ({1'b0, q.cnt} == half - 1'b1) begin
                        d.cnt   = '0;
                        d.state = line ? ST_IDLE : ST_BITS;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (!at_end) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt = '0;
                        unique case (q.state)
                            ST_BITS: begin
                                d.shreg[q.idx] = line;
                                if (q.idx == last_idx) d.state = cfg_par_en ? ST_PAR : ST_STOP;
                                else                   d.idx   = q.idx + 1'b1;
                            end
                            ST_PAR: begin
                                d.par   = line;
                                d.state = ST_STOP;
                            end
                            default: begin
                                done     = 1'b1;
                                res.data = q.shreg;
                                res.ferr = !line;
                                res.perr = cfg_par_en && ((^q.shreg ^ q.par) != cfg_par_odd);
                                res.brk  = (q.shreg == '0) && !(cfg_par_en && q.par) && !line;
                                d.brk    = res.brk;
                                d.state  = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign brk_det = q.brk;

    // R8
    brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.brk |-> q.state == ST_IDLE);

    // R7
    one_x_no_recheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_factor == FAC_1X && q.state == ST_IDLE) |=> q.state != ST_START);
endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  srx_char_t           res,
    input  logic                rd_ack,
    output logic [CHAR_MAX-1:0] data,
    output logic                ready,
    output logic                perr,
    output logic                ferr,
    output logic                ovr
);
    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                ready;
        logic                perr;
        logic                ferr;
        logic                ovr;
    } hold_st_t;

    hold_st_t q, d;

    always_comb begin
        d = q;
        if (rd_ack) d.ready = 1'b0;
        if (load) begin
            d.data  = res.data;
            d.perr  = res.perr;
            d.ferr  = res.ferr;
            d.ovr   = q.ready && !rd_ack;
            d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data  = q.data;
    assign ready = q.ready;
    assign perr  = q.perr;
    assign ferr  = q.ferr;
    assign ovr   = q.ovr;

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !load) |=> !ready);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(data) && $stable(perr) && $stable(ferr) && $stable(ovr)));

    // R5
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready && !rd_ack) |=> (ovr && ready));
endmodule

// File: rtl/serial_char_receiver.sv
module serial_char_receiver
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FAST_DIV    = 16,
    parameter int SLOW_DIV    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rxd,
    input  logic [1:0] cfg_factor,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rd_ack,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       brk_det
);
    logic      line_s;
    logic      char_done;
    srx_char_t char_res;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    srx_frame #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(samp_en), .line(line_s),
        .cfg_factor(cfg_factor), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .done(char_done), .res(char_res), .brk_det(brk_det)
    );

    srx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .load(char_done), .res(char_res),
        .rd_ack(rd_ack), .data(rx_data), .ready(rx_ready),
        .perr(err_parity), .ferr(err_frame), .ovr(err_overrun)
    );

    // R9
    deliver_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_ready);
endmodule

// File: tb/sim_serial_char_receiver.sv
module sim_serial_char_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0, rst_n = 1'b0, samp_en = 1'b0, rxd = 1'b1, rd_ack = 1'b0;
    logic [1:0] cfg_factor = 2'b01, cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_overrun, brk_det;
    int         tcnt = 0;
    int         n_cmp = 0, n_bad = 0;

    serial_char_receiver u0 (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rxd(rxd),
        .cfg_factor(cfg_factor), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rd_ack(rd_ack),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun), .brk_det(brk_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt    <= 0;
            samp_en <= 1'b0;
        end else begin
            tcnt    <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
            samp_en <= (tcnt == TICK_DIV-1);
        end
    end

    function automatic int fac_val(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 16 : 64;
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!samp_en);
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pbit, input logic stopv);
        int f;
        f = fac_val(cfg_factor);
        rxd = 1'b0;
        wait_ticks(f);
        for (int i = 0; i < 5 + int'(cfg_len); i++) begin
            rxd = d[i];
            wait_ticks(f);
        end
        if (cfg_par_en) begin
            rxd = pbit;
            wait_ticks(f);
        end
        rxd = stopv;
        wait_ticks(f);
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 400 && !rx_ready; k++) @(negedge clk);
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
        chk("R9 ready cleared by read", rx_ready, 1'b0);
    endtask

    task automatic run_char(input logic [1:0] fc, input logic [1:0] len, input logic pen,
                            input logic podd, input logic [7:0] din, input logic badp,
                            input logic badstop);
        logic [7:0] m;
        logic       pbit, e_brk;
        cfg_factor  = fc;
        cfg_len     = len;
        cfg_par_en  = pen;
        cfg_par_odd = podd;
        m     = din & len_mask(len);
        pbit  = (^m) ^ podd ^ badp;
        e_brk = (m == 8'h00) && !(pen && pbit) && badstop;
        send_frame(din, pbit, !badstop);
        wait_ready();
        chk("R7 character delivered", rx_ready, 1'b1);
        chk("R2 data right-aligned", rx_data, m);
        chk("R3 parity flag", err_parity, pen && badp);
        chk("R4 framing flag", err_frame, badstop);
        chk("R5 no overrun", err_overrun, 1'b0);
        chk("R8 break flag", brk_det, e_brk);
        rxd = 1'b1;
        wait_ticks(2);
        if (e_brk) chk("R8 break clears at mark", brk_det, 1'b0);
        ack();
        wait_ticks(2 * fac_val(fc) + 4);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", rx_ready, 1'b0);
        chk("R1 data", rx_data, 8'h00);
        chk("R1 errors", {err_parity, err_frame, err_overrun}, 3'b000);
        chk("R1 break", brk_det, 1'b0);
        wait_ticks(4);

        // R2 R7 directed: each factor, lengths, parity modes
        run_char(2'b01, 2'b11, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0);
        run_char(2'b00, 2'b00, 1'b1, 1'b0, 8'hF3, 1'b0, 1'b0);
        run_char(2'b10, 2'b10, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0);
        run_char(2'b11, 2'b01, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0);
        // R3 parity error, R4 framing error
        run_char(2'b01, 2'b11, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0);
        run_char(2'b01, 2'b10, 1'b0, 1'b0, 8'h41, 1'b0, 1'b1);

        // R6 false start: short low pulses in 16X and 64X
        cfg_factor = 2'b01;
        rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(40);
        chk("R6 glitch ignored 16X", rx_ready, 1'b0);
        cfg_factor = 2'b10;
        rxd = 1'b0; wait_ticks(20); rxd = 1'b1; wait_ticks(120);
        chk("R6 glitch ignored 64X", rx_ready, 1'b0);
        run_char(2'b01, 2'b11, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0);

        // R5 overrun: two characters without a read
        cfg_factor = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b0;
        send_frame(8'h11, 1'b0, 1'b1);
        rxd = 1'b1; wait_ready(); wait_ticks(36);
        chk("R5 first char", rx_data, 8'h11);
        send_frame(8'h22, 1'b0, 1'b1);
        rxd = 1'b1; wait_ticks(4);
        chk("R5 newer char kept", rx_data, 8'h22);
        chk("R5 overrun set", err_overrun, 1'b1);
        ack();
        wait_ticks(36);
        run_char(2'b01, 2'b11, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0);

        // R8 break held beyond the frame
        cfg_factor = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(8'h00, 1'b0, 1'b0);
        wait_ready();
        chk("R8 break detected", brk_det, 1'b1);
        chk("R8 break framing", err_frame, 1'b1);
        chk("R8 break data", rx_data, 8'h00);
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
        wait_ticks(200);
        chk("R8 no char during break", rx_ready, 1'b0);
        chk("R8 break held", brk_det, 1'b1);
        rxd = 1'b1; wait_ticks(2);
        chk("R8 break cleared", brk_det, 1'b0);
        wait_ticks(36);

        // constrained random
        void'($urandom(32'd1234));
        for (int n = 0; n < 30; n++) begin
            logic [1:0] fc;
            int         r;
            r  = $urandom % 8;
            fc = (r == 0) ? 2'b10 : (r < 4) ? 2'b00 : 2'b01;
            run_char(fc, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                     8'($urandom), ($urandom % 6) == 0, ($urandom % 8) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule